// File: doc/BRIEF.md
# Paged Management-Bus Register Sequencer

This block is a bus master that lets a controller reach a wide 32-bit register space through a narrow 16-bit management bus. Each register is addressed by byte address. The bus itself has only 5-bit PHY and 5-bit register fields. The block cuts each address into three parts: a page number, a PHY number in the range 0x10 to 0x17, and a register number. It keeps the page last written to the page-select location. It sends a page-select write only when the page it needs differs from that cached page. It then moves the two 16-bit halves of the word in a fixed order.

A controller starts one command at a time on a request/done port. The command is one of:
- a read;
- a write;
- a read-modify-write, which computes (old AND NOT mask) OR set;
- a poll, which re-reads a word until its masked value equals an expected value or a retry budget runs out;
- a debug write, which issues two unpaged writes to an index register and a data register of a chosen PHY.

The bus side is an abstract transaction port with valid/ready handshake. The serial clock and data shifting is left to a separate engine.

Top module: `mdio_paged_seq`

## Requirements
- R1: For a half-word at byte address A, the transaction uses PHY number 0x10 OR A[8:6] and register number A[5:1]. Its page is A[24:9]. Paged reads therefore always use a PHY number whose bits [4:3] are 2'b10.
- R2: Before a paged half access, the block checks the page cache. If the cache is invalid or holds a different page, it first writes the page number to PHY 0x18, register 0, and then loads the cache. Otherwise it sends no page write. Reset leaves the cache invalid.
- R3: A read (cmd_op 0) first fetches the half at A, then the half at A+2. cmd_rdata returns {high, low}.
- R4: A write (cmd_op 1) first sends cmd_wdata[31:16] to A+2, then cmd_wdata[15:0] to A.
- R5: A read-modify-write (cmd_op 2) reads the word as in R3. It then writes (old & ~cmd_mask) | cmd_set as in R4. cmd_rdata returns the old word and cmd_ok is 1.
- R6: A poll (cmd_op 3) reads the word as in R3 and compares (word & cmd_mask) with cmd_wdata. On a match it completes with cmd_ok=1 and cmd_rdata equal to the word that matched.
- R7: After each poll miss the block decrements a retry counter loaded from cmd_timeout. A miss that occurs while the counter is zero ends the command with cmd_ok=0. A poll therefore makes at most cmd_timeout+1 attempts.
- R8: After a poll miss, mdio_valid stays low for cmd_gap+1 cycles before the next attempt starts.
- R9: A debug write (cmd_op 4) writes cmd_wdata[31:16] to register 0x1D, then cmd_wdata[15:0] to register 0x1E, both on PHY cmd_addr[4:0]. It sends no page write and leaves the page cache untouched.
- R10: cmd_req is taken only while cmd_busy is low and is ignored while a command runs. cmd_done is a one-cycle pulse with cmd_busy high, and every other command completes with cmd_ok=1.
- R11: While mdio_valid is high and mdio_ready is low, the request and all its fields hold steady.
- R12: During and after reset, cmd_busy, cmd_done and mdio_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_req | input | 1 | Start a command (taken while idle) |
| cmd_op | input | 3 | 0 read, 1 write, 2 read-modify-write, 3 poll, 4 debug write |
| cmd_addr | input | ADDR_W | Byte address; debug PHY in bits [4:0] |
| cmd_wdata | input | 32 | Write data, poll expected value, or debug index/data |
| cmd_mask | input | 32 | Clear mask (modify) or compare mask (poll) |
| cmd_set | input | 32 | Bits to set in a read-modify-write |
| cmd_timeout | input | TMO_W | Poll retry budget |
| cmd_gap | input | GAP_W | Poll idle cycles minus one |
| cmd_busy | output | 1 | A command is running |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_ok | output | 1 | Completion status, 0 on poll timeout |
| cmd_rdata | output | 32 | Word read by the command |
| mdio_valid | output | 1 | Bus transaction request |
| mdio_ready | input | 1 | Bus transaction accepted |
| mdio_write | output | 1 | 1 write, 0 read |
| mdio_phy | output | 5 | PHY number |
| mdio_reg | output | 5 | Register number |
| mdio_wdata | output | 16 | Write data |
| mdio_rdata | input | 16 | Read data, valid in the cycle of acceptance |

## Verification
Directed commands check the page cache:
- a first access after reset;
- a repeat in the same page;
- a move to another page;
- a debug write between two accesses to the same page.

Together they show whether page writes are sent only when the page really changes.

Random reads, writes and read-modify-writes over four pages and random offsets run against random bus stalls. This separates a correct half-word order and field split from swapped halves or stale data, and checks that requests hold steady during stalls.

Three polls cover the other outcomes:
- a poll that matches at once;
- a poll whose high half changes on the third attempt;
- a poll that never matches.

These tell apart early success, success after retries, and exhaustion of the retry budget with the correct idle gap between attempts.

// File: rtl/mps_pkg.sv
// Shared types of the paged management-bus sequencer.
package mps_pkg;

    // Command codes seen on cmd_op.
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_RMW   = 3'd2,
        OP_POLL  = 3'd3,
        OP_DBG   = 3'd4
    } mps_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP,
        ST_DONE
    } mps_state_e;

endpackage

// File: rtl/mps_addr_split.sv
// Cuts a byte address of one half-word into page, PHY and register fields.
// Assumes ADDR_W covers the page field (PAGE_LSB + PAGE_W <= ADDR_W).
module mps_addr_split #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_W   = 16,
    parameter int PAGE_LSB = 9,
    parameter int PHY_LSB  = 6,
    parameter int REG_LSB  = 1
) (
    input  logic [ADDR_W-1:0] half_addr,
    output logic [PAGE_W-1:0] page,
    output logic [4:0]        phy,
    output logic [4:0]        regno
);
    localparam int TOP_LSB = PAGE_LSB + PAGE_W;

    // Bits outside every field, kept only to document that they are dropped.
    logic unused_bits;
    if (TOP_LSB < ADDR_W) begin : g_top
        assign unused_bits = ^{half_addr[ADDR_W-1:TOP_LSB], half_addr[0]};
    end else begin : g_notop
        assign unused_bits = half_addr[0];
    end

    // Field extraction; the PHY number always lands in the 0x10..0x17 window.
    always_comb begin
        page  = half_addr[PAGE_LSB +: PAGE_W];
        phy   = {2'b10, half_addr[PHY_LSB +: 3]};
        regno = half_addr[REG_LSB +: 5];
    end
endmodule

// File: rtl/mps_page_cache.sv
// Holds the last page written to the page-select location.
// Invalid after reset so the first paged access always selects a page.
module mps_page_cache #(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] lookup_page,
    output logic              hit,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page
);
    logic              valid_q;
    logic [PAGE_W-1:0] page_q;

    // Record the page once its select write has been accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            page_q  <= load_page;
        end
    end

    // Hit only when a page is known and equal to the one asked for.
    assign hit = valid_q && (page_q == lookup_page);
endmodule

// File: rtl/mps_retry_ctl.sv
// Retry budget and inter-attempt idle counter for poll commands.
// Assumes miss is raised only when exhausted is low.
module mps_retry_ctl #(
    parameter int TMO_W = 16,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMO_W-1:0] start_tmo,
    input  logic [GAP_W-1:0] start_gap,
    input  logic             miss,
    input  logic             in_gap,
    output logic             exhausted,
    output logic             gap_over
);
    logic [TMO_W-1:0] tmo_q;
    logic [GAP_W-1:0] gap_lim_q;
    logic [GAP_W-1:0] gap_q;

    // Load on command start, charge on a miss, count down while idling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q     <= '0;
            gap_lim_q <= '0;
            gap_q     <= '0;
        end else if (start) begin
            tmo_q     <= start_tmo;
            gap_lim_q <= start_gap;
            gap_q     <= '0;
        end else if (miss) begin
            tmo_q <= tmo_q - 1'b1;
            gap_q <= gap_lim_q;
        end else if (in_gap && gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign exhausted = (tmo_q == '0);
    assign gap_over  = (gap_q == '0);
endmodule

// File: rtl/mdio_paged_seq.sv
// Top of the paged management-bus sequencer. Runs one 32-bit command at a
// time as a list of half-word transactions, inserting a page-select write
// whenever the cached page does not match. Bus outputs are decoded from
// registered state, so a stalled request holds steady until mdio_ready.
module mdio_paged_seq
    import mps_pkg::*;
#(
    parameter int         ADDR_W       = 32,
    parameter int         TMO_W        = 16,
    parameter int         GAP_W        = 8,
    parameter logic [4:0] PAGE_PHY     = 5'h18,
    parameter logic [4:0] PAGE_REG     = 5'h00,
    parameter logic [4:0] DBG_ADDR_REG = 5'h1D,
    parameter logic [4:0] DBG_DATA_REG = 5'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_req,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [31:0]       cmd_wdata,
    input  logic [31:0]       cmd_mask,
    input  logic [31:0]       cmd_set,
    input  logic [TMO_W-1:0]  cmd_timeout,
    input  logic [GAP_W-1:0]  cmd_gap,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic              cmd_ok,
    output logic [31:0]       cmd_rdata,
    output logic              mdio_valid,
    input  logic              mdio_ready,
    output logic              mdio_write,
    output logic [4:0]        mdio_phy,
    output logic [4:0]        mdio_reg,
    output logic [15:0]       mdio_wdata,
    input  logic [15:0]       mdio_rdata
);
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    mps_state_e        state_q;
    mps_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q, mask_q, set_q, acc_q;
    logic [1:0]        step_q;
    logic              ok_q;

    logic              hi, wr, paged, last;
    logic [ADDR_W-1:0] half_addr;
    logic [HALF_W-1:0] page;
    logic [4:0]        sp_phy, sp_reg;
    logic              cache_hit, need_page;
    logic [WORD_W-1:0] wr_word, read_word;
    logic              xfer_fire, page_fire, data_fire, poll_hit;
    logic              exhausted, gap_over, poll_miss, start;

    // Per-step role of the current transaction: which half, direction, end.
    always_comb begin
        hi    = 1'b0;
        wr    = 1'b0;
        paged = 1'b1;
        last  = 1'b0;
        unique case (op_q)
            OP_READ, OP_POLL: begin
                hi   = step_q[0];
                last = (step_q == 2'd1);
            end
            OP_WRITE: begin
                hi   = ~step_q[0];
                wr   = 1'b1;
                last = (step_q == 2'd1);
            end
            OP_RMW: begin
                hi   = step_q[0] ^ step_q[1];
                wr   = step_q[1];
                last = (step_q == 2'd3);
            end
            OP_DBG: begin
                wr    = 1'b1;
                paged = 1'b0;
                last  = (step_q == 2'd1);
            end
            default: ;
        endcase
    end

    assign half_addr = addr_q + (hi ? ADDR_W'(2) : ADDR_W'(0));

    mps_addr_split #(.ADDR_W(ADDR_W), .PAGE_W(HALF_W)) u_split (
        .half_addr (half_addr),
        .page      (page),
        .phy       (sp_phy),
        .regno     (sp_reg)
    );

    mps_page_cache #(.PAGE_W(HALF_W)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .lookup_page (page),
        .hit         (cache_hit),
        .load        (page_fire),
        .load_page   (page)
    );

    mps_retry_ctl #(.TMO_W(TMO_W), .GAP_W(GAP_W)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_tmo (cmd_timeout),
        .start_gap (cmd_gap),
        .miss      (poll_miss),
        .in_gap    (state_q == ST_GAP),
        .exhausted (exhausted),
        .gap_over  (gap_over)
    );

    // Handshake qualifiers and data paths of the transaction in flight.
    always_comb begin
        need_page = paged && !cache_hit;
        xfer_fire = (state_q == ST_XFER) && mdio_ready;
        page_fire = xfer_fire && need_page;
        data_fire = xfer_fire && !need_page;
        wr_word   = (op_q == OP_RMW) ? ((acc_q & ~mask_q) | set_q) : wdata_q;
        read_word = hi ? {mdio_rdata, acc_q[HALF_W-1:0]}
                       : {acc_q[WORD_W-1:HALF_W], mdio_rdata};
        poll_hit  = ((read_word & mask_q) == wdata_q);
        poll_miss = data_fire && last && (op_q == OP_POLL) && !poll_hit && !exhausted;
        start     = (state_q == ST_IDLE) && cmd_req;
    end

    // Bus request: page select first when needed, else the half access.
    always_comb begin
        mdio_valid = (state_q == ST_XFER);
        mdio_write = 1'b1;
        mdio_phy   = PAGE_PHY;
        mdio_reg   = PAGE_REG;
        mdio_wdata = page;
        if (!need_page) begin
            mdio_write = wr;
            if (op_q == OP_DBG) begin
                mdio_phy   = addr_q[4:0];
                mdio_reg   = step_q[0] ? DBG_DATA_REG : DBG_ADDR_REG;
                mdio_wdata = step_q[0] ? wdata_q[HALF_W-1:0] : wdata_q[WORD_W-1:HALF_W];
            end else begin
                mdio_phy   = sp_phy;
                mdio_reg   = sp_reg;
                mdio_wdata = hi ? wr_word[WORD_W-1:HALF_W] : wr_word[HALF_W-1:0];
            end
        end
    end

    // Command sequencer: accept, step through halves, retry polls, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            set_q   <= '0;
            acc_q   <= '0;
            step_q  <= '0;
            ok_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cmd_req) begin
                    op_q    <= mps_op_e'(cmd_op);
                    addr_q  <= cmd_addr;
                    wdata_q <= cmd_wdata;
                    mask_q  <= cmd_mask;
                    set_q   <= cmd_set;
                    acc_q   <= '0;
                    step_q  <= '0;
                    ok_q    <= 1'b0;
                    state_q <= ST_XFER;
                end
                ST_XFER: if (data_fire) begin
                    if (!wr) acc_q <= read_word;
                    if (!last) begin
                        step_q <= step_q + 1'b1;
                    end else if (op_q != OP_POLL || poll_hit) begin
                        ok_q    <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (exhausted) begin
                        ok_q    <= 1'b0;
                        state_q <= ST_DONE;
                    end else begin
                        step_q  <= '0;
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP:  if (gap_over) state_q <= ST_XFER;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_busy  = (state_q != ST_IDLE);
    assign cmd_done  = (state_q == ST_DONE);
    assign cmd_ok    = ok_q;
    assign cmd_rdata = acc_q;
endmodule

// File: rtl/mps_checker.sv
// Temporal checks on the sequencer's ports, bound into every instance.
module mps_checker #(
    parameter logic [4:0] PAGE_PHY = 5'h18,
    parameter logic [4:0] PAGE_REG = 5'h00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_busy,
    input logic        cmd_done,
    input logic        mdio_valid,
    input logic        mdio_ready,
    input logic        mdio_write,
    input logic [4:0]  mdio_phy,
    input logic [4:0]  mdio_reg,
    input logic [15:0] mdio_wdata
);
    // Paged reads stay inside the 0x10..0x17 PHY window.
    assert_read_phy_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_valid && !mdio_write |-> mdio_phy[4:3] == 2'b10);

    // The page-select location is only ever written.
    assert_page_sel_is_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_valid && mdio_phy == PAGE_PHY && mdio_reg == PAGE_REG |-> mdio_write);

    // Completion is a single pulse, raised while busy, with the bus idle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_busy && !mdio_valid);
    assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && !cmd_done |=> cmd_busy);

    // A stalled request holds every field.
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_valid && !mdio_ready |=> mdio_valid && $stable(mdio_write) &&
        $stable(mdio_phy) && $stable(mdio_reg) && $stable(mdio_wdata));

    // Reset clears the command and bus sides.
    assert_reset_idle_R12: assert property (@(posedge clk)
        !rst_n |=> !cmd_busy && !cmd_done && !mdio_valid);
endmodule

bind mdio_paged_seq mps_checker #(.PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_busy   (cmd_busy),
    .cmd_done   (cmd_done),
    .mdio_valid (mdio_valid),
    .mdio_ready (mdio_ready),
    .mdio_write (mdio_write),
    .mdio_phy   (mdio_phy),
    .mdio_reg   (mdio_reg),
    .mdio_wdata (mdio_wdata)
);

// File: tb/mdio_paged_seq_test.sv
// Bench: bus-side register model, directed corners and seeded random commands.
module mdio_paged_seq_test;
    import mps_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_req = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0, cmd_wdata = '0, cmd_mask = '0, cmd_set = '0;
    logic [15:0] cmd_timeout = '0;
    logic [7:0]  cmd_gap = '0;
    logic        cmd_busy, cmd_done, cmd_ok;
    logic [31:0] cmd_rdata;
    logic        mdio_valid, mdio_write;
    logic        mdio_ready = 1'b1;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata;
    logic [15:0] mdio_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_paged_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
        .cmd_set(cmd_set), .cmd_timeout(cmd_timeout), .cmd_gap(cmd_gap),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
        .cmd_rdata(cmd_rdata), .mdio_valid(mdio_valid), .mdio_ready(mdio_ready),
        .mdio_write(mdio_write), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
        .mdio_wdata(mdio_wdata), .mdio_rdata(mdio_rdata)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // ---------------- bus-side register model ----------------
    logic [15:0] mem [int];
    logic [15:0] sl_page = '0;
    bit          rdy_rand = 1'b0;
    int          cyc = 0;
    int          reads_seen = 0;
    int          flip_at = -1;
    int          flip_key = 0;
    logic [15:0] flip_val = '0;
    int          log_n = 0;
    bit          lw [64];
    logic [4:0]  lphy [64], lreg [64];
    logic [15:0] ldat [64];
    int          lcyc [64];

    function automatic int mkkey(input logic [15:0] pg, input logic [4:0] p, input logic [4:0] r);
        return int'({6'b0, pg, p, r});
    endfunction

    function automatic int key_of(input logic [31:0] a);
        return mkkey(a[24:9], {2'b10, a[8:6]}, a[5:1]);
    endfunction

    function automatic logic [15:0] rdm(input int key);
        if (mem.exists(key)) return mem[key];
        return 16'((key * 40503) ^ 32'h5A5A);
    endfunction

    function automatic logic [31:0] val32(input logic [31:0] a);
        return {rdm(key_of(a + 32'd2)), rdm(key_of(a))};
    endfunction

    // Drive ready and read data away from the active edge.
    always @(negedge clk) begin
        mdio_ready = rdy_rand ? 1'($urandom % 2) : 1'b1;
        mdio_rdata = rdm(mkkey(sl_page, mdio_phy, mdio_reg));
    end

    // Log every accepted transaction and apply it to the model.
    always @(posedge clk) begin
        if (rst_n && mdio_valid && mdio_ready) begin
            if (log_n < 64) begin
                lw[log_n] = mdio_write;  lphy[log_n] = mdio_phy;
                lreg[log_n] = mdio_reg;  ldat[log_n] = mdio_wdata;
                lcyc[log_n] = cyc;
            end
            log_n++;
            if (mdio_write) begin
                if (mdio_phy == 5'h18 && mdio_reg == 5'h00) sl_page = mdio_wdata;
                else mem[mkkey(sl_page, mdio_phy, mdio_reg)] = mdio_wdata;
            end else begin
                reads_seen++;
                if (reads_seen == flip_at) mem[flip_key] = flip_val;
            end
        end
        cyc++;
    end

    // ---------------- expected transaction lists ----------------
    int          exp_n = 0;
    bit          ew [64];
    logic [4:0]  ephy [64], ereg [64];
    logic [15:0] edat [64];
    bit          exp_pv = 1'b0;
    logic [15:0] exp_pg = '0;

    task automatic exp_push(input bit w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        if (exp_n < 64) begin
            ew[exp_n] = w; ephy[exp_n] = p; ereg[exp_n] = r; edat[exp_n] = d;
        end
        exp_n++;
    endtask

    // One paged half: page select when the bench's own page model misses (R2).
    task automatic exp_half(input bit w, input logic [31:0] a, input logic [15:0] d);
        if (!exp_pv || exp_pg != a[24:9]) begin
            exp_push(1'b1, 5'h18, 5'h00, a[24:9]);
            exp_pv = 1'b1;
            exp_pg = a[24:9];
        end
        exp_push(w, {2'b10, a[8:6]}, a[5:1], d);
    endtask

    task automatic exp_read(input logic [31:0] a);
        exp_half(1'b0, a, 16'h0);
        exp_half(1'b0, a + 32'd2, 16'h0);
    endtask

    task automatic exp_write(input logic [31:0] a, input logic [31:0] v);
        exp_half(1'b1, a + 32'd2, v[31:16]);
        exp_half(1'b1, a, v[15:0]);
    endtask

    task automatic cmp_seq(input string req);
        int bad = -1;
        logic [31:0] act = '0, exq = '0;
        check(log_n == exp_n, req, "transaction count", log_n, exp_n);
        if (log_n == exp_n) begin
            for (int i = 0; i < exp_n && i < 64; i++) begin
                if (bad < 0 && (lw[i] != ew[i] || lphy[i] != ephy[i] || lreg[i] != ereg[i] ||
                                (ew[i] && ldat[i] != edat[i]))) begin
                    bad = i;
                    act = {5'b0, lw[i], lphy[i], lreg[i], lw[i] ? ldat[i] : 16'h0};
                    exq = {5'b0, ew[i], ephy[i], ereg[i], ew[i] ? edat[i] : 16'h0};
                end
            end
            check(bad < 0, req, $sformatf("transaction %0d {w,phy,reg,data}", bad), act, exq);
        end
    endtask

    task automatic begin_cmd();
        log_n = 0;
        exp_n = 0;
        reads_seen = 0;
    endtask

    logic        r_ok;
    logic [31:0] r_data;

    // Issue one command; optionally re-request while busy (R10).
    task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] wd,
                       input logic [31:0] mk, input logic [31:0] st,
                       input logic [15:0] tmo, input logic [7:0] gp, input bit poke);
        cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_mask = mk; cmd_set = st;
        cmd_timeout = tmo; cmd_gap = gp; cmd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0;
        check(cmd_busy == 1'b1, "R10", "busy after request", {31'b0, cmd_busy}, 32'd1);
        if (poke) begin
            cmd_op = OP_WRITE; cmd_addr = 32'h00FF_FFF0; cmd_req = 1'b1;
            @(negedge clk);
            @(negedge clk);
            cmd_req = 1'b0;
        end
        while (!cmd_done) @(negedge clk);
        r_ok = cmd_ok;
        r_data = cmd_rdata;
        @(negedge clk);
        check(cmd_done == 1'b0, "R10", "done lasts one cycle", {31'b0, cmd_done}, 32'd0);
        check(cmd_busy == 1'b0, "R10", "idle after done", {31'b0, cmd_busy}, 32'd0);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [31:0] a, v, d, old, mk, st, nv, pa;
        logic [15:0] pgs [4];
        int seed_val;
        seed_val = $urandom(32'd20240607);
        pgs[0] = 16'h0000; pgs[1] = 16'h0001; pgs[2] = 16'h01F3; pgs[3] = 16'hFFFF;

        // R12: reset state.
        repeat (4) @(negedge clk);
        check(!cmd_busy, "R12", "busy in reset", {31'b0, cmd_busy}, 0);
        check(!cmd_done, "R12", "done in reset", {31'b0, cmd_done}, 0);
        check(!mdio_valid, "R12", "valid in reset", {31'b0, mdio_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_busy && !mdio_valid, "R12", "idle after reset", {30'b0, cmd_busy, mdio_valid}, 0);

        // R2 R3: first read after reset selects page 9, low half then high.
        a = 32'h0000_1234; v = val32(a);
        begin_cmd(); exp_read(a);
        run(OP_READ, a, 0, 0, 0, 0, 0, 1'b0);
        cmp_seq("R2");
        check(r_data == v, "R3", "read data", r_data, v);
        check(r_ok, "R10", "read ok", {31'b0, r_ok}, 1);

        // R2: same page again, no select; R10: request while busy ignored.
        a = 32'h0000_1238; v = val32(a);
        begin_cmd(); exp_read(a);
        run(OP_READ, a, 0, 0, 0, 0, 0, 1'b1);
        cmp_seq("R10");
        check(r_data == v, "R3", "read data same page", r_data, v);

        // R1: top of a PHY block, registers 0x1E and 0x1F of PHY 0x17.
        a = 32'h0000_01FC; v = val32(a);
        begin_cmd(); exp_read(a);
        run(OP_READ, a, 0, 0, 0, 0, 0, 1'b0);
        cmp_seq("R1");
        check(r_data == v, "R1", "read data at field edge", r_data, v);

        // R4: write to a new page, high half first; read back.
        a = 32'h0003_0010; d = 32'hCAFE_F00D;
        begin_cmd(); exp_write(a, d);
        run(OP_WRITE, a, d, 0, 0, 0, 0, 1'b0);
        cmp_seq("R4");
        check(val32(a) == d, "R4", "stored word", val32(a), d);

        // R5: read-modify-write returns the old word and stores the new one.
        old = val32(a); mk = 32'hFF00_00F0; st = 32'h1200_0005;
        nv = (old & ~mk) | st;
        begin_cmd(); exp_read(a); exp_write(a, nv);
        run(OP_RMW, a, 0, mk, st, 0, 0, 1'b0);
        cmp_seq("R5");
        check(r_data == old, "R5", "old word returned", r_data, old);
        check(val32(a) == nv, "R5", "modified word", val32(a), nv);

        // R9: debug write is unpaged and leaves the cache alone.
        begin_cmd();
        exp_push(1'b1, 5'd1, 5'h1D, 16'hA5C3);
        exp_push(1'b1, 5'd1, 5'h1E, 16'h0F0F);
        run(OP_DBG, 32'h0000_0001, 32'hA5C3_0F0F, 0, 0, 0, 0, 1'b0);
        cmp_seq("R9");
        begin_cmd(); exp_read(a);
        run(OP_READ, a, 0, 0, 0, 0, 0, 1'b0);
        cmp_seq("R9");

        // R6: poll matches on the first attempt.
        pa = 32'h0000_4A08; v = val32(pa); mk = 32'h00FF_FF00;
        begin_cmd(); exp_read(pa);
        run(OP_POLL, pa, v & mk, mk, 0, 16'd5, 8'd1, 1'b0);
        cmp_seq("R6");
        check(r_ok, "R6", "poll ok", {31'b0, r_ok}, 1);
        check(r_data == v, "R6", "poll word", r_data, v);

        // R7 R8: poll never matches, 4 attempts, idle gap of 3 cycles.
        v = val32(pa);
        begin_cmd();
        for (int k = 0; k < 4; k++) exp_read(pa);
        run(OP_POLL, pa, ~v, 32'hFFFF_FFFF, 0, 16'd3, 8'd2, 1'b0);
        cmp_seq("R7");
        check(!r_ok, "R7", "poll timeout status", {31'b0, r_ok}, 0);
        check(lcyc[2] - lcyc[1] == 4, "R8", "cycles between attempts", lcyc[2] - lcyc[1], 4);

        // R6 R7: high half changes after the fifth read, match on attempt 3.
        rdy_rand = 1'b1;
        mem[key_of(pa + 32'd2)] = 16'h1111;
        flip_key = key_of(pa + 32'd2); flip_val = 16'hBEEF;
        begin_cmd(); flip_at = 5;
        for (int k = 0; k < 3; k++) exp_read(pa);
        run(OP_POLL, pa, 32'hBEEF_0000, 32'hFFFF_0000, 0, 16'd6, 8'd3, 1'b0);
        flip_at = -1;
        cmp_seq("R7");
        check(r_ok, "R6", "late poll ok", {31'b0, r_ok}, 1);
        check(r_data[31:16] == 16'hBEEF, "R6", "late poll high half", r_data, 32'hBEEF_0000);

        // R1 R3 R4 R5 R11: random commands over four pages with random stalls.
        for (int n = 0; n < 60; n++) begin
            a = {7'b0, pgs[$urandom % 4], 7'($urandom), 2'b00};
            case ($urandom % 3)
                0: begin
                    v = val32(a);
                    begin_cmd(); exp_read(a);
                    run(OP_READ, a, 0, 0, 0, 0, 0, 1'b0);
                    cmp_seq("R1");
                    check(r_data == v, "R3", "random read", r_data, v);
                end
                1: begin
                    d = $urandom;
                    begin_cmd(); exp_write(a, d);
                    run(OP_WRITE, a, d, 0, 0, 0, 0, 1'b0);
                    cmp_seq("R4");
                    check(val32(a) == d, "R4", "random write", val32(a), d);
                end
                default: begin
                    old = val32(a); mk = $urandom; st = $urandom;
                    nv = (old & ~mk) | st;
                    begin_cmd(); exp_read(a); exp_write(a, nv);
                    run(OP_RMW, a, 0, mk, st, 0, 0, 1'b0);
                    cmp_seq("R5");
                    check(r_data == old && val32(a) == nv, "R5", "random modify", val32(a), nv);
                end
            endcase
        end

        report();
        $finish;
    end
endmodule